// File: doc/BRIEF.md
# Smooth Digital Clock Calibrator

This block trims the effective rate of a reference pulse stream by deleting or adding pulses inside a fixed calibration window of 2^WIN_LOG2 input pulses (2^20 by default). Each input pulse arrives as a one-cycle `tick_in`; the block passes it on `ce_out` unless it is one of the pulses chosen for removal. Removed pulses are placed by a carry accumulator, so they are spread evenly over the window rather than bunched together. When the add setting is on, a fixed 512 extra pulses per window are inserted, one after every 2^(WIN_LOG2-9) input pulses, on the first following cycle that carries no input pulse. The corrected stream feeds a downstream prescaler.

A signed correction c is written as an add bit and a 9-bit remove count: a positive c (1 to 512) is written as add=1, remove=512-c; a negative c is written as add=0, remove=|c|, with software saturating at 511. One step is about 0.95 ppm with the default window, giving roughly -487 ppm to +488 ppm. A write is staged and a pending flag rises; the staged value, including a stored low-power mode bit, becomes active at the next window boundary, where the flag drops. Writes made while the flag is high are dropped.

Top module: `smooth_cal`

## Requirements
- R1: After reset, `pending` is 0 and `act_add`, `act_mask` and `act_lowpwr` are 0; with that setting every input pulse is passed, so a window yields exactly 2^WIN_LOG2 output pulses.
- R2: With `act_add`=0, a window of 2^WIN_LOG2 input pulses yields exactly 2^WIN_LOG2 - `act_mask` output pulses, and an input pulse is never removed while `act_mask` is 0.
- R3: Removed pulses are spread evenly: of the first 2^(WIN_LOG2-1) input pulses of a window, exactly floor(`act_mask`/2) are removed.
- R4: With `act_add`=1, one extra pulse is owed after each group of 2^(WIN_LOG2-9) input pulses and is emitted on the next cycle with `tick_in` low; a window therefore carries 512 inserted pulses and 2^WIN_LOG2 - `act_mask` + 512 pulses in total.
- R5: A write (`wr_en`=1 while `pending`=0) raises `pending` on the next cycle and leaves the active setting unchanged.
- R6: The staged setting becomes active on the clock edge that takes the last input pulse of a window (which itself still uses the old setting), and `pending` falls on that same edge.
- R7: A write presented while `pending` is 1 is ignored; the setting that becomes active is the earlier staged one.
- R8: The low-power mode bit is staged with the add bit and remove count and appears on `act_lowpwr` at the same boundary.
- R9: `ce_out` is high in a cycle with `tick_in` low only to emit an owed inserted pulse; with `act_add`=0 no pulse is inserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_in | input | 1 | Reference input pulse, one cycle wide |
| wr_en | input | 1 | Setting write strobe |
| wr_add | input | 1 | Add bit of the written setting |
| wr_mask | input | 9 | Remove count of the written setting |
| wr_lowpwr | input | 1 | Low-power mode bit of the written setting |
| ce_out | output | 1 | Corrected clock-enable stream |
| pending | output | 1 | A staged setting awaits the next window boundary |
| act_add | output | 1 | Active add bit |
| act_mask | output | 9 | Active remove count |
| act_lowpwr | output | 1 | Active low-power mode bit |

## Verification
The bench counts output pulses over whole windows for remove counts 0, 100, 256, 511 and for the add bit with remove counts 212 and 0; an off-by-one in the window counter or accumulator carry shows up as a total that misses by one, and a lost insertion shows as an inserted count below 512. Half-window removal counts catch a design that removes pulses in a burst at the start or end of the window instead of spreading them. A second write during the pending period checks that it is dropped: a design that overwrites the staged value activates the wrong count and low-power bit. The pending flag and active outputs are sampled right after each write and right after each boundary, catching a design that applies a setting at once or one window late.

// File: rtl/smooth_cal_pkg.sv
package smooth_cal_pkg;
  localparam int unsigned CAL_MASK_W = 9;

  typedef struct packed {
    logic                  add;
    logic [CAL_MASK_W-1:0] mask;
    logic                  lowpwr;
  } cal_cfg_t;
endpackage

// File: rtl/cal_rst_sync.sv
module cal_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/cal_cfg_regs.sv
module cal_cfg_regs
  import smooth_cal_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr_en,
  input  cal_cfg_t wr_cfg,
  input  logic     win_wrap,
  output logic     pending,
  output cal_cfg_t act_cfg
);
  cal_cfg_t stage_q, stage_d;
  cal_cfg_t act_q, act_d;
  logic     pend_q, pend_d;
  logic     accept;
  logic     stage_en;
  logic     act_en;

  always_comb begin
    accept   = wr_en & ~pend_q;
    stage_en = accept;
    act_en   = win_wrap & pend_q;
    stage_d  = wr_cfg;
    act_d    = stage_q;
    pend_d   = pend_q;
    if (accept)      pend_d = 1'b1;
    else if (act_en) pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      act_q   <= '0;
      pend_q  <= 1'b0;
    end else begin
      if (stage_en) stage_q <= stage_d;
      if (act_en)   act_q   <= act_d;
      pend_q <= pend_d;
    end
  end

  assign pending = pend_q;
  assign act_cfg = act_q;
endmodule

// File: rtl/cal_window.sv
module cal_window #(
  parameter int unsigned WIN_LOG2 = 20,
  parameter int unsigned MASK_W   = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_in,
  input  logic [MASK_W-1:0] mask_cnt,
  output logic              win_wrap,
  output logic              grp_end,
  output logic              drop
);
  localparam int unsigned GRP_LOG2 = WIN_LOG2 - MASK_W;

  logic [WIN_LOG2-1:0] cnt_q, cnt_d;
  logic [WIN_LOG2-1:0] acc_q, acc_d;
  logic [WIN_LOG2:0]   acc_sum;

  always_comb begin
    acc_sum  = {1'b0, acc_q} + (WIN_LOG2+1)'(mask_cnt);
    win_wrap = tick_in & (&cnt_q);
    grp_end  = tick_in & (&cnt_q[GRP_LOG2-1:0]);
    drop     = tick_in & acc_sum[WIN_LOG2];
    cnt_d    = cnt_q + 1'b1;
    acc_d    = win_wrap ? '0 : acc_sum[WIN_LOG2-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      acc_q <= '0;
    end else if (tick_in) begin
      cnt_q <= cnt_d;
      acc_q <= acc_d;
    end
  end
endmodule

// File: rtl/cal_insert.sv
module cal_insert (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_in,
  input  logic grp_end,
  input  logic add_en,
  output logic ins
);
  logic owed_q, owed_d;

  always_comb begin
    ins    = owed_q & ~tick_in;
    owed_d = owed_q;
    if (grp_end & add_en) owed_d = 1'b1;
    else if (ins)         owed_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) owed_q <= 1'b0;
    else        owed_q <= owed_d;
  end
endmodule

// File: rtl/smooth_cal.sv
module smooth_cal
  import smooth_cal_pkg::*;
#(
  parameter int unsigned WIN_LOG2 = 20
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick_in,
  input  logic                  wr_en,
  input  logic                  wr_add,
  input  logic [CAL_MASK_W-1:0] wr_mask,
  input  logic                  wr_lowpwr,
  output logic                  ce_out,
  output logic                  pending,
  output logic                  act_add,
  output logic [CAL_MASK_W-1:0] act_mask,
  output logic                  act_lowpwr
);
  logic     rst_n_s;
  logic     win_wrap;
  logic     grp_end;
  logic     drop;
  logic     ins;
  cal_cfg_t wr_cfg;
  cal_cfg_t act_cfg;

  assign wr_cfg = '{add: wr_add, mask: wr_mask, lowpwr: wr_lowpwr};

  cal_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  cal_cfg_regs u_cfg (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .wr_en    (wr_en),
    .wr_cfg   (wr_cfg),
    .win_wrap (win_wrap),
    .pending  (pending),
    .act_cfg  (act_cfg)
  );

  cal_window #(.WIN_LOG2(WIN_LOG2), .MASK_W(CAL_MASK_W)) u_win (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .tick_in  (tick_in),
    .mask_cnt (act_cfg.mask),
    .win_wrap (win_wrap),
    .grp_end  (grp_end),
    .drop     (drop)
  );

  cal_insert u_ins (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .tick_in (tick_in),
    .grp_end (grp_end),
    .add_en  (act_cfg.add),
    .ins     (ins)
  );

  assign ce_out     = (tick_in & ~drop) | ins;
  assign act_add    = act_cfg.add;
  assign act_mask   = act_cfg.mask;
  assign act_lowpwr = act_cfg.lowpwr;
endmodule

// File: rtl/smooth_cal_chk.sv
module smooth_cal_chk #(
  parameter int unsigned MASK_W = 9
) (
  input logic              clk,
  input logic              rst_n_s,
  input logic              tick_in,
  input logic              wr_en,
  input logic              win_wrap,
  input logic              ce_out,
  input logic              pending,
  input logic              act_add,
  input logic [MASK_W-1:0] act_mask,
  input logic              act_lowpwr
);
  // R5
  write_sets_pending_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (wr_en && !pending) |=> pending);

  // R6
  boundary_clears_pending_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (win_wrap && pending) |=> !pending);

  // R6
  active_only_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    !win_wrap |=> ($stable(act_mask) && $stable(act_add) && $stable(act_lowpwr)));

  // R2
  no_drop_when_zero_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (tick_in && act_mask == '0) |-> ce_out);

  // R9
  insert_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!tick_in && ce_out) |-> $past(tick_in));
endmodule

bind smooth_cal smooth_cal_chk #(.MASK_W(smooth_cal_pkg::CAL_MASK_W)) u_chk (
  .clk        (clk),
  .rst_n_s    (rst_n_s),
  .tick_in    (tick_in),
  .wr_en      (wr_en),
  .win_wrap   (win_wrap),
  .ce_out     (ce_out),
  .pending    (pending),
  .act_add    (act_add),
  .act_mask   (act_mask),
  .act_lowpwr (act_lowpwr)
);

// File: tb/smooth_cal_tb.sv
module smooth_cal_tb;
  localparam int WIN_LOG2 = 12;
  localparam int N        = 1 << WIN_LOG2;
  localparam int HALF     = N / 2;
  localparam int NWIN     = 7;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_in = 1'b0;
  logic       wr_en = 1'b0;
  logic       wr_add = 1'b0;
  logic [8:0] wr_mask = '0;
  logic       wr_lowpwr = 1'b0;
  logic       ce_out, pending, act_add, act_lowpwr;
  logic [8:0] act_mask;

  smooth_cal #(.WIN_LOG2(WIN_LOG2)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .wr_en(wr_en),
    .wr_add(wr_add), .wr_mask(wr_mask), .wr_lowpwr(wr_lowpwr),
    .ce_out(ce_out), .pending(pending), .act_add(act_add),
    .act_mask(act_mask), .act_lowpwr(act_lowpwr)
  );

  always #4 clk = ~clk;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  typedef struct {int tot; int half; int ins; int add;} exp_t;
  exp_t q[$];

  // monitor
  bit run = 1'b0;
  int pulse_in_win = 0;
  int win_idx = 0;
  int tot = 0, half_m = 0, ins_n = 0;
  bit close_next = 1'b0;

  always @(negedge clk) begin
    if (run) begin
      if (ce_out) tot++;
      if (tick_in && !ce_out && pulse_in_win < HALF) half_m++;
      if (!tick_in && ce_out) ins_n++;
      if (close_next) begin
        if (q.size() == 0) begin
          check(1'b0, "R2 queue", 0, 1);
        end else begin
          exp_t e;
          e = q.pop_front();
          check(tot == e.tot, e.add ? "R4 total" : "R2 total", tot, e.tot);
          check(half_m == e.half, "R3 half-window drops", half_m, e.half);
          check(ins_n == e.ins, e.add ? "R4 inserts" : "R9 inserts", ins_n, e.ins);
        end
        tot = 0; half_m = 0; ins_n = 0;
        close_next = 1'b0;
        win_idx++;
      end
      if (tick_in) begin
        if (pulse_in_win == N - 1) begin
          close_next   = 1'b1;
          pulse_in_win = 0;
        end else begin
          pulse_in_win++;
        end
      end
    end
  end

  // input pulse generator: one pulse every other cycle
  initial begin
    wait (run);
    forever begin
      @(posedge clk);
      #1 tick_in = ~tick_in;
    end
  end

  task automatic do_write(input bit a, input int m, input bit lp);
    @(posedge clk);
    #1;
    wr_en = 1'b1; wr_add = a; wr_mask = 9'(m); wr_lowpwr = lp;
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  // scenario per window
  bit wdo [NWIN] = '{1, 1, 1, 1, 1, 0, 0};
  bit wa  [NWIN] = '{0, 1, 0, 1, 0, 0, 0};
  int wm  [NWIN] = '{100, 212, 511, 0, 256, 0, 0};
  bit wl  [NWIN] = '{1, 0, 0, 0, 1, 0, 0};

  // driver
  initial begin
    bit m_add, m_lp, s_add, s_lp, staged;
    int m_mask, s_mask;
    m_add = 0; m_mask = 0; m_lp = 0; s_add = 0; s_mask = 0; s_lp = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(pending == 1'b0, "R1 pending after reset", pending, 0);
    check(act_mask == 9'd0 && act_add == 1'b0, "R1 active after reset", act_mask, 0);
    check(act_lowpwr == 1'b0, "R1 lowpwr after reset", act_lowpwr, 0);
    check(ce_out == 1'b0, "R9 idle output", ce_out, 0);
    run = 1'b1;
    for (int w = 0; w < NWIN; w++) begin
      wait (win_idx == w);
      @(negedge clk);
      if (w > 0) begin
        check(pending == 1'b0, "R6 pending cleared at boundary", pending, 0);
        check(int'(act_mask) == m_mask, "R6 active mask", act_mask, m_mask);
        check(act_add == m_add, "R6 active add", act_add, m_add);
        check(act_lowpwr == m_lp, "R8 active lowpwr", act_lowpwr, m_lp);
      end
      q.push_back('{tot: N - m_mask + (m_add ? 512 : 0), half: m_mask / 2,
                    ins: m_add ? 512 : 0, add: int'(m_add)});
      staged = 0;
      if (wdo[w]) begin
        wait (pulse_in_win >= 1000);
        do_write(wa[w], wm[w], wl[w]);
        @(negedge clk);
        check(pending == 1'b1, "R5 pending after write", pending, 1);
        check(int'(act_mask) == m_mask, "R5 active unchanged", act_mask, m_mask);
        s_add = wa[w]; s_mask = wm[w]; s_lp = wl[w]; staged = 1;
        if (w == 1) begin
          // R7: second write while pending must be dropped
          do_write(1'b0, 5, 1'b1);
          @(negedge clk);
          check(pending == 1'b1, "R7 pending held", pending, 1);
        end
      end
      if (staged) begin
        m_add = s_add; m_mask = s_mask; m_lp = s_lp;
      end
    end
    wait (win_idx == NWIN);
    @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", win_idx, NWIN);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule